// File: doc/BRIEF.md
# 32-to-8-bit Bus Narrowing Bridge

This block sits between a 32-bit host data bus, whose four byte lanes are qualified by active-low enables, and a byte-wide peripheral bus. Only one byte lane is ever connected to the narrow side. A lane numbered k carries address offset k within a doubleword, on host data bits 8k+7 down to 8k. So byte-wide devices can sit at consecutive addresses without two of them being written together.

A request names any subset of the four lanes. The bridge walks the enabled lanes from the lowest index to the highest and runs one narrow-bus cycle per lane. Each narrow cycle drives the lane index on the two narrow address bits and holds a read or write strobe for a parameterised number of clocks. On writes the bridge steers the selected lane down to the narrow data bus. On reads it latches each returned byte into its lane of a 32-bit return register.

The bridge also presents the host write word as it would appear on the full-width bus. When a write enables only upper-half lanes, the upper 16 bits are copied onto the lower 16 bits. The host sees a single-clock ready pulse once the last enabled byte is done. A request with no lanes enabled completes on the next clock without touching the narrow bus.

Top module: `bus_narrow_bridge`

## Requirements
- R1: During each narrow cycle serving lane k (k = 0..3), `nb_addr` equals k. On writes, `nb_wdata` equals host write bits [8k+7:8k] as sampled when the request was accepted.
- R2: The enabled lanes (bit k of `host_be_n` low) are each served exactly once, in ascending index order.
- R3: Each narrow cycle holds its strobe for exactly CYC_CLKS consecutive clocks. `nb_rd` is used for reads (`host_we` = 0) and `nb_wr` for writes, and the two are never high together.
- R4: For k enabled lanes, `host_rdy` is high for one clock only. That clock is 1 + k·CYC_CLKS clocks after the accepting edge, and no strobe is active in it.
- R5: A request with `host_be_n` = 4'b1111 starts no narrow cycle and raises `host_rdy` in the first clock after acceptance.
- R6: On reads, the byte on `nb_rdata` at the last strobe clock of lane k is placed in `host_rdata` bits [8k+7:8k]. Lanes not enabled read 0. Any accepted request clears the register first, and the value then holds until the next accepted request.
- R7: `host_wbus` equals {`host_wdata`[31:16], `host_wdata`[31:16]} when `host_we` is 1, `host_be_n`[1:0] = 2'b11 and `host_be_n`[3:2] ≠ 2'b11. Otherwise it equals `host_wdata`.
- R8: `host_req` asserted while a transfer is in progress is ignored. The running sequence is unchanged and no further cycle or ready follows.
- R9: While `rst_n` is low at a clock edge, the bridge returns to idle, with both strobes, `host_rdy` and `host_rdata` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request, accepted on a clock edge while idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_be_n | input | 4 | Active-low byte lane enables, bit k = lane k |
| host_wdata | input | 32 | Host write data |
| host_wbus | output | 32 | Write word as driven on the full-width bus, with upper-half copy |
| host_rdata | output | 32 | Assembled read data |
| host_rdy | output | 1 | One-clock completion pulse |
| nb_addr | output | 2 | Narrow-bus low address bits (lane index) |
| nb_wdata | output | 8 | Narrow-bus write data |
| nb_rdata | input | 8 | Narrow-bus read data |
| nb_rd | output | 1 | Narrow-bus read strobe |
| nb_wr | output | 1 | Narrow-bus write strobe |

## Verification
The hardest situations to reach from the ports are a new request arriving in the middle of a four-lane transfer and a reset landing while a strobe is high. The bench raises `host_req` with a different enable pattern two clocks into a full-width transfer. It then checks that the lane sequence, the ready timing and the following idle clocks are untouched. It also drops reset in the middle of a read and checks the narrow strobes and the return word. Around these, every enable pattern is swept for both directions. The narrow-side read bytes depend on the address, so a byte landing in the wrong lane shows up as a wrong value.

// File: rtl/bnb_pkg.sv
// Package: shared sizes and the sequencer state type for the bus
// narrowing bridge. Assumes a host bus made of LANES byte lanes.
package bnb_pkg;
    localparam int LANES      = 4;
    localparam int LANE_W     = 8;
    localparam int BUS_W      = LANES * LANE_W;
    localparam int HALF_W     = BUS_W / 2;
    localparam int LANE_IDX_W = $clog2(LANES);

    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_XFER = 1'b1
    } seq_state_t;
endpackage

// File: rtl/bnb_lane_pick.sv
// Module: lowest-index lane picker. Given a mask of lanes still to be
// served, returns the index of the lowest set bit. Assumes the caller
// only uses the result when the mask is non-zero.
module bnb_lane_pick
    import bnb_pkg::*;
(
    input  logic [LANES-1:0]      mask,
    output logic [LANE_IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (mask[i]) idx = LANE_IDX_W'(i);
        end
    end
endmodule

// File: rtl/bnb_seq.sv
// Module: transfer sequencer. Accepts a request when idle, then runs one
// narrow cycle of CYC_CLKS clocks per enabled lane, lowest lane first,
// and pulses ready after the last one. Assumes CYC_CLKS >= 1.
module bnb_seq
    import bnb_pkg::*;
#(
    parameter int CYC_CLKS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_req,
    input  logic                  host_we,
    input  logic [LANES-1:0]      host_be_n,
    output logic [LANE_IDX_W-1:0] lane,
    output logic                  accept,
    output logic                  cap_en,
    output logic                  strobe_rd,
    output logic                  strobe_wr,
    output logic                  host_rdy,
    output logic                  busy
);
    localparam int CNT_W = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYC_CLKS - 1);

    seq_state_t       state;
    logic [LANES-1:0] pend;
    logic [LANES-1:0] lane_oh;
    logic [LANES-1:0] pend_rest;
    logic [CNT_W-1:0] cnt;
    logic             we_q;
    logic             last_clk;

    bnb_lane_pick u_pick (
        .mask (pend),
        .idx  (lane)
    );

    // One-hot form of the current lane and the lanes left after it.
    always_comb begin
        lane_oh       = '0;
        lane_oh[lane] = 1'b1;
        pend_rest     = pend & ~lane_oh;
    end

    assign busy      = (state == SQ_XFER);
    assign accept    = (state == SQ_IDLE) && host_req;
    assign last_clk  = busy && (cnt == CNT_LAST);
    assign cap_en    = last_clk && !we_q;
    assign strobe_rd = busy && !we_q;
    assign strobe_wr = busy && we_q;

    // State, lane mask, clock counter and ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            pend     <= '0;
            cnt      <= '0;
            we_q     <= 1'b0;
            host_rdy <= 1'b0;
        end else begin
            host_rdy <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (host_req) begin
                        pend <= ~host_be_n;
                        we_q <= host_we;
                        cnt  <= '0;
                        if (&host_be_n) host_rdy <= 1'b1;
                        else            state    <= SQ_XFER;
                    end
                end
                SQ_XFER: begin
                    if (last_clk) begin
                        cnt  <= '0;
                        pend <= pend_rest;
                        if (pend_rest == '0) begin
                            state    <= SQ_IDLE;
                            host_rdy <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bnb_datapath.sv
// Module: lane steering datapath. Forms the full-width write word with
// the upper-half copy, holds it for the transfer, steers the selected
// lane to the narrow bus and assembles read bytes into their lanes.
// Assumes accept and cap_en come from the sequencer.
module bnb_datapath
    import bnb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic                  cap_en,
    input  logic                  host_we,
    input  logic [LANES-1:0]      host_be_n,
    input  logic [BUS_W-1:0]      host_wdata,
    input  logic [LANE_IDX_W-1:0] lane,
    input  logic [LANE_W-1:0]     nb_rdata,
    output logic [BUS_W-1:0]      host_wbus,
    output logic [LANE_W-1:0]     nb_wdata,
    output logic [BUS_W-1:0]      host_rdata
);
    logic             upper_only;
    logic [BUS_W-1:0] wbus_q;
    logic [LANE_W-1:0] rd_q [LANES];

    // Upper-half-only write: copy the top half onto the bottom half.
    always_comb begin
        upper_only = host_we && (&host_be_n[LANES/2-1:0])
                             && !(&host_be_n[LANES-1:LANES/2]);
        host_wbus  = upper_only ? {host_wdata[BUS_W-1:HALF_W], host_wdata[BUS_W-1:HALF_W]}
                                : host_wdata;
    end

    // Hold the write word for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)      wbus_q <= '0;
        else if (accept) wbus_q <= host_wbus;
    end

    assign nb_wdata = wbus_q[lane*LANE_W +: LANE_W];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Per-lane read byte: cleared on accept, loaded on its last strobe clock.
        always_ff @(posedge clk) begin
            if (!rst_n || accept)                        rd_q[g] <= '0;
            else if (cap_en && lane == LANE_IDX_W'(g))   rd_q[g] <= nb_rdata;
        end
        assign host_rdata[g*LANE_W +: LANE_W] = rd_q[g];
    end
endmodule

// File: rtl/bus_narrow_bridge.sv
// Module: top of the 32-to-8-bit bus narrowing bridge. Connects the
// sequencer and the datapath. Assumes one host request at a time;
// requests raised while busy are dropped.
module bus_narrow_bridge
    import bnb_pkg::*;
#(
    parameter int CYC_CLKS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_req,
    input  logic                  host_we,
    input  logic [LANES-1:0]      host_be_n,
    input  logic [BUS_W-1:0]      host_wdata,
    output logic [BUS_W-1:0]      host_wbus,
    output logic [BUS_W-1:0]      host_rdata,
    output logic                  host_rdy,
    output logic [LANE_IDX_W-1:0] nb_addr,
    output logic [LANE_W-1:0]     nb_wdata,
    input  logic [LANE_W-1:0]     nb_rdata,
    output logic                  nb_rd,
    output logic                  nb_wr
);
    logic [LANE_IDX_W-1:0] lane;
    logic                  accept;
    logic                  cap_en;
    logic                  busy;

    bnb_seq #(.CYC_CLKS(CYC_CLKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_req  (host_req),
        .host_we   (host_we),
        .host_be_n (host_be_n),
        .lane      (lane),
        .accept    (accept),
        .cap_en    (cap_en),
        .strobe_rd (nb_rd),
        .strobe_wr (nb_wr),
        .host_rdy  (host_rdy),
        .busy      (busy)
    );

    bnb_datapath u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .cap_en     (cap_en),
        .host_we    (host_we),
        .host_be_n  (host_be_n),
        .host_wdata (host_wdata),
        .lane       (lane),
        .nb_rdata   (nb_rdata),
        .host_wbus  (host_wbus),
        .nb_wdata   (nb_wdata),
        .host_rdata (host_rdata)
    );

    assign nb_addr = lane;
endmodule

// File: rtl/bnb_checker.sv
// Module: protocol checker for the bridge, bound to the top module.
// Tracks strobe run lengths with a counter instead of deep $past.
module bnb_checker #(
    parameter int CYC_CLKS = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_req,
    input logic [3:0] host_be_n,
    input logic       busy,
    input logic       host_rdy,
    input logic       nb_rd,
    input logic       nb_wr,
    input logic [1:0] nb_addr
);
    logic        strobe;
    logic        prev_strobe;
    logic [1:0]  prev_addr;
    int unsigned run_len;
    logic        seg_end;
    logic        addr_step;

    assign strobe    = nb_rd || nb_wr;
    assign seg_end   = prev_strobe && (!strobe || nb_addr != prev_addr);
    assign addr_step = prev_strobe && strobe && (nb_addr != prev_addr);

    // Length of the current run of strobe clocks on one address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_strobe <= 1'b0;
            prev_addr   <= '0;
            run_len     <= 0;
        end else begin
            prev_strobe <= strobe;
            prev_addr   <= nb_addr;
            if (!strobe)                                 run_len <= 0;
            else if (prev_strobe && nb_addr == prev_addr) run_len <= run_len + 1;
            else                                         run_len <= 1;
        end
    end

    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(nb_rd && nb_wr));

    assert_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seg_end |-> (run_len == CYC_CLKS));

    assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_step |-> (nb_addr > prev_addr));

    assert_rdy_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdy |=> !host_rdy);

    assert_rdy_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdy |-> !strobe);

    assert_empty_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !busy && (&host_be_n)) |=> (host_rdy && !strobe));
endmodule

bind bus_narrow_bridge bnb_checker #(.CYC_CLKS(CYC_CLKS)) u_chk (.*);

// File: tb/tb_bus_narrow_bridge.sv
// Bench: sweeps every enable pattern in both directions, plus a request
// raised while busy and a reset in the middle of a transfer.
module tb_bus_narrow_bridge;
    localparam int CYC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_be_n = 4'hF;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_wbus;
    logic [31:0] host_rdata;
    logic        host_rdy;
    logic [1:0]  nb_addr;
    logic [7:0]  nb_wdata;
    logic [7:0]  nb_rdata;
    logic        nb_rd;
    logic        nb_wr;
    logic [7:0]  rd_seed = 8'h00;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    // Narrow-side device: the byte returned depends on the address.
    assign nb_rdata = rd_seed + 8'(nb_addr) * 8'h11;

    bus_narrow_bridge #(.CYC_CLKS(CYC)) dut (.*);

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h (t=%0t)", rq, act, exp, $time);
        end
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_fail++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 50000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // One request, checked clock by clock against the arithmetic model.
    task automatic run_txn(input logic [3:0] be, input logic we, input logic [31:0] wd,
                           input logic [7:0] seed, input bit inject);
        int          lanes [4];
        int          k = 0;
        int          total;
        logic [31:0] exp_rd = '0;
        logic [31:0] exp_wb;
        for (int i = 0; i < 4; i++) begin
            if (!be[i]) begin
                lanes[k] = i;
                k++;
                exp_rd[i*8 +: 8] = seed + 8'(i) * 8'h11;
            end
        end
        if (we) exp_rd = '0;
        total = k * CYC + 1;
        @(negedge clk);
        host_req = 1'b1; host_be_n = be; host_we = we; host_wdata = wd; rd_seed = seed;
        #1;
        exp_wb = (we && be[1:0] == 2'b11 && be[3:2] != 2'b11) ? {wd[31:16], wd[31:16]} : wd;
        chk(host_wbus == exp_wb, "R7", host_wbus, exp_wb);
        @(negedge clk);
        host_req = 1'b0; host_wdata = ~wd; host_be_n = 4'hF;
        for (int c = 1; c <= total + 3; c++) begin
            bit on;
            on = (c <= k * CYC);
            if (inject && c == 2) begin
                host_req = 1'b1; host_be_n = 4'hE; host_we = ~we;
            end
            if (inject && c == 3) begin
                host_req = 1'b0; host_be_n = 4'hF;
            end
            chk(nb_rd == (on && !we), inject ? "R8" : "R3", {31'd0, nb_rd}, {31'd0, on && !we});
            chk(nb_wr == (on && we), inject ? "R8" : "R3", {31'd0, nb_wr}, {31'd0, on && we});
            if (on) begin
                int ln;
                ln = lanes[(c - 1) / CYC];
                chk(nb_addr == 2'(ln), "R2", {30'd0, nb_addr}, ln);
                if (we) chk(nb_wdata == wd[ln*8 +: 8], "R1", {24'd0, nb_wdata}, {24'd0, wd[ln*8 +: 8]});
            end
            if (k == 0) chk(host_rdy == (c == total), "R5", {31'd0, host_rdy}, {31'd0, c == total});
            else        chk(host_rdy == (c == total), "R4", {31'd0, host_rdy}, {31'd0, c == total});
            if (c >= total) chk(host_rdata == exp_rd, "R6", host_rdata, exp_rd);
            @(negedge clk);
        end
    endtask

    initial begin
        // R9: outputs quiet while reset is held.
        repeat (3) @(negedge clk);
        chk(!nb_rd && !nb_wr, "R9", {30'd0, nb_rd, nb_wr}, 0);
        chk(!host_rdy, "R9", {31'd0, host_rdy}, 0);
        chk(host_rdata == 0, "R9", host_rdata, 0);
        rst_n = 1'b1;

        // Sweep every enable pattern, both directions.
        for (int we = 0; we < 2; we++) begin
            for (int be = 0; be < 16; be++) begin
                run_txn(4'(be), we[0], 32'hC3A5_0F96 + 32'(be) * 32'h0101_0101 + 32'(we),
                        8'h20 + 8'(be), 1'b0);
            end
        end

        // R8: a new request during a full-width transfer is dropped.
        run_txn(4'h0, 1'b0, 32'h0, 8'h5A, 1'b1);
        run_txn(4'h0, 1'b1, 32'hDEAD_BEEF, 8'h00, 1'b1);

        // R9: reset in the middle of a read.
        @(negedge clk);
        host_req = 1'b1; host_be_n = 4'h0; host_we = 1'b0; rd_seed = 8'h77;
        @(negedge clk);
        host_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(nb_rd, "R9", {31'd0, nb_rd}, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!nb_rd && !nb_wr, "R9", {30'd0, nb_rd, nb_wr}, 0);
        chk(host_rdata == 0, "R9", host_rdata, 0);
        chk(!host_rdy, "R9", {31'd0, host_rdy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!nb_rd && !nb_wr && !host_rdy, "R9", {29'd0, nb_rd, nb_wr, host_rdy}, 0);
        run_txn(4'h6, 1'b0, 32'h0, 8'h90, 1'b0);
        run_txn(4'h3, 1'b1, 32'h1122_3344, 8'h00, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule